// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block drives and samples a parameterised number of general-purpose pins, grouped into banks of up to 32 pins each. Software reaches it through a simple 32-bit register bus with one-cycle read latency. For each bank it can read the pin levels, choose per pin whether the pin drives, and change the output latch through two write-only ports. One port sets the bits written as 1 and the other clears them, so no read-modify-write is needed.

Each input pin passes through a two-flop synchronizer. The synchronized value is compared with its value one cycle earlier to find rising and falling transitions. Separate per-pin enables decide which transitions are captured into a sticky status register, which software clears by writing ones. A per-bank gating register selects which captured events reach the single combined interrupt output.

The register windows of the banks are interleaved. Registers of the same kind in neighbouring banks sit one word apart, and banks from index 3 upward live in a second window 0x100 higher.

Top module: `gpio_banked`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), pin_out is all 0, irq is 0, and the direction, rising-enable, falling-enable, status and gate registers of every bank read 0.
- R2: Register kinds sit at byte offsets level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48 and gate 0x9C. Bank n < 3 adds 4·n to the offset and bank n ≥ 3 adds 0x100 + 4·(n−3). Any other address, a misaligned address, or a bank beyond the last one reads 0 and ignores writes.
- R3: A write to the set port drives high every output-latch bit written as 1 and leaves the other bits unchanged. The set port reads as 0.
- R4: A write to the clear port drives low every output-latch bit written as 1 and leaves the other bits unchanged. The clear port reads as 0.
- R5: A direction bit of 1 makes that pin drive (pin_oe = 1) and 0 makes it an input. The direction register reads back as written, and pin_out shows the latch whatever the direction.
- R6: The level register returns pin_in after a two-flop synchronizer, whatever the direction. A read issued in the same cycle that a pin changes still returns the old value, and a read issued three cycles later returns the new one.
- R7: A 0→1 transition sets the status bit when the rising enable is 1. A 1→0 transition sets it when the falling enable is 1. The two enables act independently per pin.
- R8: Status bits stay set until a 1 is written to them. Writing 0 to a status bit has no effect.
- R9: When a transition is captured in the same cycle that software writes 1 to clear that status bit, the bit stays set.
- R10: irq is 1 exactly when some bank has a status bit that is set and whose gate bit is also 1.
- R11: In a partial last bank, bits at and above the implemented pin count read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS | Output latch per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | Combined gated edge interrupt |

## Verification
The bench builds the block with NUM_PINS = 100 and ADDR_W = 10. That gives four banks: three full banks in the low window and one bank of four pins in the high window. This configuration exercises the interleaved decode in both windows, the unmapped slot just past the last bank, an aliasing address above the decoded range, and the masking of a partial bank. Every bank gets a distinct arithmetic pattern in every writable register, and expected latch, status and interrupt values come from a per-bank model kept in the bench. One test places a clear write in the exact cycle that an edge is captured.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W = 32;

    // register kind = (word index within a window) / 3
    typedef enum logic [3:0] {
        RK_LEVEL = 4'd0,
        RK_DIR   = 4'd1,
        RK_SET   = 4'd2,
        RK_CLR   = 4'd3,
        RK_RISE  = 4'd4,
        RK_FALL  = 4'd5,
        RK_STAT  = 4'd6,
        RK_GATE  = 4'd13,
        RK_NONE  = 4'd15
    } reg_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] out;
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] rise;
        logic [WORD_W-1:0] fall;
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] gate;
        logic [WORD_W-1:0] prev;
    } bank_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_o = sy_q.s2;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NBANKS = 4,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  bank_idx,
    output reg_kind_e         kind
);
    logic [5:0] word;
    logic [5:0] kind_num;
    logic [5:0] sub;
    int         bank_num;

    always_comb begin
        word     = addr[7:2];
        kind_num = word / 6'd3;
        sub      = word % 6'd3;
        bank_num = (addr[8] ? 3 : 0) + int'(sub);
        case (kind_num)
            6'd0:    kind = RK_LEVEL;
            6'd1:    kind = RK_DIR;
            6'd2:    kind = RK_SET;
            6'd3:    kind = RK_CLR;
            6'd4:    kind = RK_RISE;
            6'd5:    kind = RK_FALL;
            6'd6:    kind = RK_STAT;
            6'd13:   kind = RK_GATE;
            default: kind = RK_NONE;
        endcase
        hit      = ((addr >> 9) == '0) && (addr[1:0] == 2'b00)
                   && (kind != RK_NONE) && (bank_num < NBANKS);
        bank_idx = IDX_W'(bank_num);
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] lvl,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] out_o,
    output logic [WORD_W-1:0] oe_o,
    output logic              irq_o
);
    localparam logic [WORD_W-1:0] VMASK =
        (W >= WORD_W) ? {WORD_W{1'b1}} : ((WORD_W'(1) << W) - WORD_W'(1));

    bank_state_t       st_d, st_q;
    logic [WORD_W-1:0] wd, lv, rise_hit, fall_hit, clr;

    always_comb begin
        st_d     = st_q;
        wd       = wdata & VMASK;
        lv       = lvl & VMASK;
        rise_hit = lv & ~st_q.prev & st_q.rise;
        fall_hit = ~lv & st_q.prev & st_q.fall;
        clr      = '0;
        st_d.prev = lv;
        if (wr_en) begin
            case (kind)
                RK_DIR:  st_d.dir  = wd;
                RK_SET:  st_d.out  = st_q.out | wd;
                RK_CLR:  st_d.out  = st_q.out & ~wd;
                RK_RISE: st_d.rise = wd;
                RK_FALL: st_d.fall = wd;
                RK_STAT: clr       = wd;
                RK_GATE: st_d.gate = wd;
                default: ;
            endcase
        end
        // a fresh capture overrides a simultaneous clear
        st_d.stat = (st_q.stat & ~clr) | rise_hit | fall_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (kind)
            RK_LEVEL: rd_data = lv;
            RK_DIR:   rd_data = st_q.dir;
            RK_RISE:  rd_data = st_q.rise;
            RK_FALL:  rd_data = st_q.fall;
            RK_STAT:  rd_data = st_q.stat;
            RK_GATE:  rd_data = st_q.gate;
            default:  rd_data = '0;
        endcase
    end

    assign out_o = st_q.out;
    assign oe_o  = st_q.dir;
    assign irq_o = |(st_q.stat & st_q.gate);

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_SET) |=> ((st_q.out & $past(wd)) == $past(wd)));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_CLR) |=> ((st_q.out & $past(wd)) == '0));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && kind == RK_STAT) |=> ((st_q.stat & $past(st_q.stat)) == $past(st_q.stat)));

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise_hit | fall_hit)) |=>
            ((st_q.stat & $past(rise_hit | fall_hit)) == $past(rise_hit | fall_hit)));
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 120,
    parameter int ADDR_W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NBANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int IDX_W  = (NBANKS > 1) ? $clog2(NBANKS) : 1;

    logic [NUM_PINS-1:0]      pin_sync;
    logic [NBANKS*WORD_W-1:0] lvl_img;
    logic                     hit;
    logic [IDX_W-1:0]         bank_idx;
    reg_kind_e                kind;
    logic [WORD_W-1:0]        bank_rd  [NBANKS];
    logic [WORD_W-1:0]        bank_out [NBANKS];
    logic [WORD_W-1:0]        bank_oe  [NBANKS];
    logic [NBANKS-1:0]        bank_irq;
    logic [WORD_W-1:0]        rd_d, rd_q;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(pin_sync)
    );

    gpio_addr_dec #(.ADDR_W(ADDR_W), .NBANKS(NBANKS), .IDX_W(IDX_W)) u_dec (
        .addr(bus_addr), .hit(hit), .bank_idx(bank_idx), .kind(kind)
    );

    always_comb begin
        lvl_img = '0;
        lvl_img[NUM_PINS-1:0] = pin_sync;
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam int BW = (b == NBANKS - 1) ? (NUM_PINS - b * WORD_W) : WORD_W;
        logic wr_en;
        assign wr_en = bus_sel && bus_wr && hit && (bank_idx == IDX_W'(b));
        gpio_bank #(.W(BW)) u_bank (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .kind(kind),
            .wdata(bus_wdata), .lvl(lvl_img[b*WORD_W +: WORD_W]),
            .rd_data(bank_rd[b]), .out_o(bank_out[b]), .oe_o(bank_oe[b]),
            .irq_o(bank_irq[b])
        );
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign pin_out[i] = bank_out[i / WORD_W][i % WORD_W];
        assign pin_oe[i]  = bank_oe[i / WORD_W][i % WORD_W];
    end

    always_comb begin
        rd_d = rd_q;
        if (bus_sel && !bus_wr)
            rd_d = hit ? bank_rd[bank_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;
    assign irq       = |bank_irq;

    p_unmapped_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !hit) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_gpio_banked.sv
module tb_gpio_banked;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 100;
    localparam int NB = 4;
    localparam logic [9:0] O_LVL = 10'h00, O_DIR = 10'h0C, O_SET = 10'h18, O_CLR = 10'h24,
                           O_RISE = 10'h30, O_FALL = 10'h3C, O_STAT = 10'h48, O_GATE = 10'h9C;

    logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0, irq;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
    logic [127:0] pins_img = '0;
    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] m_out [NB];
    logic [31:0] m_dir [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_banked #(.NUM_PINS(NP), .ADDR_W(10)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [9:0] ra(int b, logic [9:0] off);
        return (b < 3) ? off + 10'(4 * b) : 10'h100 + off + 10'(4 * (b - 3));
    endfunction
    function automatic logic [31:0] vm(int b);
        return (b == NB - 1) ? 32'hF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [31:0] pat(int b, int k);
        return 32'h9E37_79B9 * 32'(b * 8 + k + 1);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask
    task automatic wr(logic [9:0] a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask
    task automatic rd(logic [9:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata; bus_sel = 0;
    endtask
    task automatic rdchk(string tag, logic [9:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask
    task automatic pins(logic [127:0] v);
        pins_img = v; pin_in = v[NP-1:0];
    endtask
    function automatic logic [31:0] oslice(int b);
        logic [127:0] t = {28'b0, pin_out};
        return t[b*32 +: 32];
    endfunction
    function automatic logic [31:0] eslice(int b);
        logic [127:0] t = {28'b0, pin_oe};
        return t[b*32 +: 32];
    endfunction
    task automatic check_pins(string tag);
        for (int b = 0; b < NB; b++) begin
            chk({tag, " pin_out"}, oslice(b), m_out[b]);
            chk({tag, " pin_oe"}, eslice(b), m_dir[b]);
        end
    endtask
    task automatic clear_all_status();
        for (int b = 0; b < NB; b++) wr(ra(b, O_STAT), 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int b = 0; b < NB; b++) begin m_out[b] = '0; m_dir[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        check_pins("R1");
        for (int b = 0; b < NB; b++) begin
            rdchk("R1 dir", ra(b, O_DIR), 0);
            rdchk("R1 rise", ra(b, O_RISE), 0);
            rdchk("R1 fall", ra(b, O_FALL), 0);
            rdchk("R1 stat", ra(b, O_STAT), 0);
            rdchk("R1 gate", ra(b, O_GATE), 0);
        end

        // R2 interleaved map: distinct pattern per bank and kind
        for (int b = 0; b < NB; b++) begin
            wr(ra(b, O_DIR), pat(b, 0));  m_dir[b] = pat(b, 0) & vm(b);
            wr(ra(b, O_RISE), pat(b, 1));
            wr(ra(b, O_FALL), pat(b, 2));
            wr(ra(b, O_GATE), pat(b, 3));
        end
        for (int b = 0; b < NB; b++) begin
            rdchk("R2 dir", ra(b, O_DIR), pat(b, 0) & vm(b));
            rdchk("R2 rise", ra(b, O_RISE), pat(b, 1) & vm(b));
            rdchk("R2 fall", ra(b, O_FALL), pat(b, 2) & vm(b));
            rdchk("R2 gate", ra(b, O_GATE), pat(b, 3) & vm(b));
        end
        wr(10'h110, 32'hFFFF_FFFF);   // slot past the last bank
        wr(10'h20C, 32'hFFFF_FFFF);   // above the decoded range
        wr(10'h00D, 32'hFFFF_FFFF);   // misaligned
        rdchk("R2 alias bank0 dir", ra(0, O_DIR), pat(0, 0));
        rdchk("R2 unmapped 0x0FC", 10'h0FC, 0);
        rdchk("R2 unmapped 0x110", 10'h110, 0);
        rdchk("R2 unmapped 0x20C", 10'h20C, 0);
        rdchk("R2 unmapped 0x1FC", 10'h1FC, 0);
        check_pins("R5 after dir");

        // R3 R4 R5 set / clear sweep
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < NB; b++) begin
                d = pat(b, 4 + i);
                if (i % 2 == 0) begin wr(ra(b, O_SET), d); m_out[b] = m_out[b] | (d & vm(b)); end
                else            begin wr(ra(b, O_CLR), d); m_out[b] = m_out[b] & ~(d & vm(b)); end
            end
            check_pins((i % 2 == 0) ? "R3 set" : "R4 clear");
        end
        for (int b = 0; b < NB; b++) begin
            rdchk("R3 set reads 0", ra(b, O_SET), 0);
            rdchk("R4 clear reads 0", ra(b, O_CLR), 0);
            wr(ra(b, O_DIR), ~m_dir[b]); m_dir[b] = ~m_dir[b] & vm(b);
        end
        check_pins("R5 dir flip");

        // R6 level readback through synchronizer
        pins(128'h0);
        repeat (3) @(negedge clk);
        pins({32'h0, 32'h1357_9BDF, 32'h0F0F_F0F0, 32'hCAFE_F00D});
        rdchk("R6 latency old", ra(0, O_LVL), 0);
        repeat (3) @(negedge clk);
        for (int b = 0; b < NB; b++) rdchk("R6 level", ra(b, O_LVL), pins_img[b*32 +: 32] & vm(b));
        pins(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
        repeat (3) @(negedge clk);
        for (int b = 0; b < NB; b++) rdchk("R6 level ones", ra(b, O_LVL), vm(b));

        // R7 independent edges
        pins(128'h0);
        for (int b = 0; b < NB; b++) begin
            wr(ra(b, O_RISE), 0); wr(ra(b, O_FALL), 0); wr(ra(b, O_GATE), 0);
        end
        repeat (3) @(negedge clk);
        clear_all_status();
        wr(ra(0, O_RISE), 32'h0000_FFFF); wr(ra(0, O_FALL), 32'h00FF_00FF);
        wr(ra(3, O_RISE), 32'h3);         wr(ra(3, O_FALL), 32'hFFFF_FFF5);
        pins(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
        repeat (3) @(negedge clk);
        rdchk("R7 rise b0", ra(0, O_STAT), 32'h0000_FFFF);
        rdchk("R7 rise b1", ra(1, O_STAT), 0);
        rdchk("R7 rise b3", ra(3, O_STAT), 32'h3);
        clear_all_status();
        pins(128'h0);
        repeat (3) @(negedge clk);
        rdchk("R7 fall b0", ra(0, O_STAT), 32'h00FF_00FF);
        rdchk("R7 fall b2", ra(2, O_STAT), 0);
        rdchk("R7 fall b3", ra(3, O_STAT), 32'h5);

        // R10 gated interrupt
        chk("R10 gate closed", {31'b0, irq}, 0);
        wr(ra(3, O_GATE), 32'h4);
        chk("R10 pending gated", {31'b0, irq}, 1);
        wr(ra(3, O_GATE), 32'h2);
        chk("R10 gate on idle bit", {31'b0, irq}, 0);
        wr(ra(0, O_GATE), 32'h0000_0100);
        chk("R10 bank0 pending", {31'b0, irq}, 0);
        wr(ra(0, O_GATE), 32'h0001_0000);
        chk("R10 bank0 pending hi", {31'b0, irq}, 1);
        wr(ra(0, O_GATE), 0);

        // R8 sticky, write-one-to-clear
        wr(ra(0, O_STAT), 0);
        rdchk("R8 zero write", ra(0, O_STAT), 32'h00FF_00FF);
        wr(ra(0, O_STAT), 32'h0000_000F);
        rdchk("R8 partial clear", ra(0, O_STAT), 32'h00FF_00F0);
        repeat (4) @(negedge clk);
        rdchk("R8 holds idle", ra(0, O_STAT), 32'h00FF_00F0);

        // R9 edge coincides with clear
        clear_all_status();
        wr(ra(0, O_RISE), 32'h1); wr(ra(0, O_FALL), 32'h1);
        pins(128'h1);
        repeat (3) @(negedge clk);
        rdchk("R9 armed", ra(0, O_STAT), 32'h1);
        pins(128'h0);
        @(negedge clk); @(negedge clk);
        wr(ra(0, O_STAT), 32'h1);     // lands on the capture edge
        rdchk("R9 edge wins", ra(0, O_STAT), 32'h1);
        wr(ra(0, O_STAT), 32'h1);
        rdchk("R9 later clear", ra(0, O_STAT), 0);

        // R11 partial last bank
        wr(ra(3, O_DIR), 32'hFFFF_FFFF); m_dir[3] = 32'hF;
        rdchk("R11 dir", ra(3, O_DIR), 32'hF);
        wr(ra(3, O_CLR), 32'hFFFF_FFFF); m_out[3] = 0;
        wr(ra(3, O_SET), 32'hFFFF_FFF0);
        check_pins("R11");
        wr(ra(3, O_GATE), 32'hFFFF_FFF0);
        rdchk("R11 gate", ra(3, O_GATE), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule